// File: doc/BRIEF.md
# Two-Bank Register File with Pointer Indirection

This block is the data-memory front end of a small 8-bit controller core. The core presents a 7-bit register address on a combinational read port and a 7-bit address with data on a write port. The block resolves each address to one storage location, keeping its own status and pointer registers. Bit 5 of the status register chooses between two banks for direct addresses. In each bank, offsets 0x00 to 0x0B are control locations and offsets 0x0C to 0x4F are 68 bytes of general RAM. That RAM is a single array, so both banks reach the same byte at the same offset. Offsets above 0x4F are unimplemented.

Offset 0x00 has no storage. An access to it is redirected through the pointer register. Pointer bits 6:0 give the target offset and pointer bit 7 gives the target bank. The status bank bit and status bit 7 play no part in this. When the redirected offset is 0x00 again, a read returns zero and a write is dropped. The status register sits at offset 0x03 and the pointer at 0x04, and each appears at that offset in both banks. The remaining control offsets (0x01, 0x02, 0x05 to 0x0B) are plain byte registers, and each bank has its own copy.

Top module: `bregfile_top`

## Requirements
- R1: After reset the status and pointer registers are 0x00, and every location reads 0x00.
- R2: A direct access to control offsets 0x01, 0x02 and 0x05 to 0x0B reaches a separate byte per bank. The bank is status bit 5 (0 = bank 0, 1 = bank 1).
- R3: Direct offsets 0x0C to 0x4F reach one shared 68-byte array, whatever the value of status bit 5.
- R4: The status register is at offset 0x03 and the pointer at offset 0x04 in both banks. Both are readable there, writable there, and always visible on `status_o` and `ptr_o`.
- R5: A direct read of offsets 0x50 to 0x7F returns 0x00, and a direct write there changes no location.
- R6: An access to offset 0x00 reaches offset pointer[6:0] in bank pointer[7]. Status bits 5 and 7 do not affect it.
- R7: A read of offset 0x00 while pointer[6:0] is 0x00 returns 0x00, for either value of pointer[7].
- R8: A write to offset 0x00 while pointer[6:0] is 0x00 changes no location.
- R9: An indirect access whose pointer[6:0] exceeds 0x4F reads 0x00 and writes nothing.
- R10: Reads are combinational from the current state. A write takes effect at the next rising clock edge, so a read in the same cycle returns the old value. A status write that changes the bank affects only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr | input | 7 | Read address (direct offset, or 0x00 for indirect) |
| rd_data | output | 8 | Read data, combinational |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_addr | input | 7 | Write address (direct offset, or 0x00 for indirect) |
| wr_data | input | 8 | Write data |
| status_o | output | 8 | Current status register |
| ptr_o | output | 8 | Current pointer register |

## Verification
The assertions check the following on every cycle:
- a read of 0x50 and above returns zero;
- a self-referencing indirect read returns zero;
- the status and pointer registers appear at their own offsets and through the pointer;
- a status write lands on the next edge;
- self-referencing and unimplemented writes leave the status and pointer alone.

Some behaviour depends on what was stored earlier, so only the bench scenarios can show it. This covers:
- bank separation of the control bytes;
- sharing of the RAM across banks;
- redirection into a chosen bank by pointer bit 7 when the status bank disagrees;
- the old-value read during a same-cycle write.

// File: rtl/bregfile_pkg.sv
package bregfile_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_INDIR,
        TGT_STATUS,
        TGT_PTR,
        TGT_SCRATCH,
        TGT_GPR
    } tgt_kind_e;

    typedef struct packed {
        tgt_kind_e         kind;
        logic              bank;
        logic [ADDR_W-1:0] idx;
    } tgt_t;
endpackage

// File: rtl/bank_decode.sv
module bank_decode
    import bregfile_pkg::*;
#(
    parameter int SFR_CNT     = 12,
    parameter int TOP_ADDR    = 'h4F,
    parameter int INDIR_ADDR  = 0,
    parameter int STATUS_ADDR = 3,
    parameter int PTR_ADDR    = 4
) (
    input  logic              bank,
    input  logic [ADDR_W-1:0] addr,
    output tgt_t              tgt
);
    localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(TOP_ADDR);
    localparam logic [ADDR_W-1:0] IND_A = ADDR_W'(INDIR_ADDR);
    localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] PTR_A = ADDR_W'(PTR_ADDR);
    localparam logic [ADDR_W-1:0] SFR_A = ADDR_W'(SFR_CNT);

    always_comb begin
        tgt.bank = bank;
        tgt.idx  = addr;
        if (addr > TOP_A) begin
            tgt.kind = TGT_NONE;
        end else if (addr == IND_A) begin
            tgt.kind = TGT_INDIR;
        end else if (addr == STS_A) begin
            tgt.kind = TGT_STATUS;
        end else if (addr == PTR_A) begin
            tgt.kind = TGT_PTR;
        end else if (addr < SFR_A) begin
            tgt.kind = TGT_SCRATCH;
        end else begin
            tgt.kind = TGT_GPR;
            tgt.idx  = addr - SFR_A;
        end
    end
endmodule

// File: rtl/access_resolve.sv
module access_resolve
    import bregfile_pkg::*;
#(
    parameter int SFR_CNT     = 12,
    parameter int TOP_ADDR    = 'h4F,
    parameter int INDIR_ADDR  = 0,
    parameter int STATUS_ADDR = 3,
    parameter int PTR_ADDR    = 4
) (
    input  logic              dir_bank,
    input  logic [DATA_W-1:0] ptr,
    input  logic [ADDR_W-1:0] addr,
    output tgt_t              tgt
);
    tgt_t dir_tgt;
    tgt_t ind_tgt;

    bank_decode #(
        .SFR_CNT(SFR_CNT), .TOP_ADDR(TOP_ADDR), .INDIR_ADDR(INDIR_ADDR),
        .STATUS_ADDR(STATUS_ADDR), .PTR_ADDR(PTR_ADDR)
    ) i_dir (
        .bank(dir_bank),
        .addr(addr),
        .tgt (dir_tgt)
    );

    bank_decode #(
        .SFR_CNT(SFR_CNT), .TOP_ADDR(TOP_ADDR), .INDIR_ADDR(INDIR_ADDR),
        .STATUS_ADDR(STATUS_ADDR), .PTR_ADDR(PTR_ADDR)
    ) i_ind (
        .bank(ptr[DATA_W-1]),
        .addr(ptr[ADDR_W-1:0]),
        .tgt (ind_tgt)
    );

    always_comb begin
        tgt = dir_tgt;
        if (dir_tgt.kind == TGT_INDIR) begin
            tgt = ind_tgt;
            if (ind_tgt.kind == TGT_INDIR) begin
                tgt.kind = TGT_NONE;
            end
        end
    end
endmodule

// File: rtl/reg_store.sv
module reg_store
    import bregfile_pkg::*;
#(
    parameter int SFR_CNT  = 12,
    parameter int TOP_ADDR = 'h4F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tgt_t              rd_tgt,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  tgt_t              wr_tgt,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] ptr_q
);
    localparam int GPR_CNT = TOP_ADDR + 1 - SFR_CNT;
    localparam int GPR_IW  = $clog2(GPR_CNT);
    localparam int SCR_IW  = $clog2(SFR_CNT);
    localparam int NBANK   = 2;

    logic [DATA_W-1:0] scr_q [NBANK][SFR_CNT];
    logic [DATA_W-1:0] gpr_q [GPR_CNT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            ptr_q    <= '0;
            for (int b = 0; b < NBANK; b++) begin
                for (int i = 0; i < SFR_CNT; i++) begin
                    scr_q[b][i] <= '0;
                end
            end
            for (int g = 0; g < GPR_CNT; g++) begin
                gpr_q[g] <= '0;
            end
        end else if (wr_en) begin
            unique case (wr_tgt.kind)
                TGT_STATUS:  status_q <= wr_data;
                TGT_PTR:     ptr_q    <= wr_data;
                TGT_SCRATCH: scr_q[wr_tgt.bank][wr_tgt.idx[SCR_IW-1:0]] <= wr_data;
                TGT_GPR:     gpr_q[wr_tgt.idx[GPR_IW-1:0]] <= wr_data;
                default:     ;
            endcase
        end
    end

    always_comb begin
        unique case (rd_tgt.kind)
            TGT_STATUS:  rd_data = status_q;
            TGT_PTR:     rd_data = ptr_q;
            TGT_SCRATCH: rd_data = scr_q[rd_tgt.bank][rd_tgt.idx[SCR_IW-1:0]];
            TGT_GPR:     rd_data = gpr_q[rd_tgt.idx[GPR_IW-1:0]];
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/bregfile_top.sv
module bregfile_top
    import bregfile_pkg::*;
#(
    parameter int SFR_CNT     = 12,
    parameter int TOP_ADDR    = 'h4F,
    parameter int INDIR_ADDR  = 0,
    parameter int STATUS_ADDR = 3,
    parameter int PTR_ADDR    = 4,
    parameter int BANK_BIT    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] status_o,
    output logic [DATA_W-1:0] ptr_o
);
    tgt_t rd_tgt;
    tgt_t wr_tgt;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] ptr_q;

    access_resolve #(
        .SFR_CNT(SFR_CNT), .TOP_ADDR(TOP_ADDR), .INDIR_ADDR(INDIR_ADDR),
        .STATUS_ADDR(STATUS_ADDR), .PTR_ADDR(PTR_ADDR)
    ) i_rd_res (
        .dir_bank(status_q[BANK_BIT]),
        .ptr     (ptr_q),
        .addr    (rd_addr),
        .tgt     (rd_tgt)
    );

    access_resolve #(
        .SFR_CNT(SFR_CNT), .TOP_ADDR(TOP_ADDR), .INDIR_ADDR(INDIR_ADDR),
        .STATUS_ADDR(STATUS_ADDR), .PTR_ADDR(PTR_ADDR)
    ) i_wr_res (
        .dir_bank(status_q[BANK_BIT]),
        .ptr     (ptr_q),
        .addr    (wr_addr),
        .tgt     (wr_tgt)
    );

    reg_store #(
        .SFR_CNT(SFR_CNT), .TOP_ADDR(TOP_ADDR)
    ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_tgt  (rd_tgt),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_tgt  (wr_tgt),
        .wr_data (wr_data),
        .status_q(status_q),
        .ptr_q   (ptr_q)
    );

    assign status_o = status_q;
    assign ptr_o    = ptr_q;
endmodule

// File: rtl/bregfile_chk.sv
module bregfile_chk
    import bregfile_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] status_o,
    input logic [DATA_W-1:0] ptr_o
);
    localparam logic [ADDR_W-1:0] TOP_A = 7'h4F;
    localparam logic [ADDR_W-1:0] IND_A = 7'h00;
    localparam logic [ADDR_W-1:0] STS_A = 7'h03;
    localparam logic [ADDR_W-1:0] PTR_A = 7'h04;

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > TOP_A) |-> (rd_data == '0)); // R5

    AST_UNMAPPED_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > TOP_A) |=> ($stable(status_o) && $stable(ptr_o))); // R5

    AST_STATUS_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == STS_A) |-> (rd_data == status_o)); // R4

    AST_PTR_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == PTR_A) |-> (rd_data == ptr_o)); // R4

    AST_STATUS_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == STS_A) |=> (status_o == $past(wr_data))); // R10

    AST_INDIRECT_TO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == IND_A && ptr_o[ADDR_W-1:0] == STS_A) |-> (rd_data == status_o)); // R6

    AST_SELF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == IND_A && ptr_o[ADDR_W-1:0] == IND_A) |-> (rd_data == '0)); // R7

    AST_SELF_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == IND_A && ptr_o[ADDR_W-1:0] == IND_A)
        |=> ($stable(status_o) && $stable(ptr_o))); // R8

    AST_INDIRECT_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == IND_A && ptr_o[ADDR_W-1:0] > TOP_A) |-> (rd_data == '0)); // R9
endmodule

bind bregfile_top bregfile_chk i_chk (.*);

// File: tb/test_bregfile_top.sv
module test_bregfile_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] rd_addr;
    logic [7:0] rd_data;
    logic       wr_en;
    logic [6:0] wr_addr;
    logic [7:0] wr_data;
    logic [7:0] status_o;
    logic [7:0] ptr_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_stat;
    logic [7:0] m_ptr;
    logic [7:0] m_mem [0:1023];

    always #5 clk = ~clk;

    bregfile_top i_bregfile_top (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .status_o(status_o), .ptr_o(ptr_o)
    );

    // Location key: -1 none, 1000 status, 1001 pointer, 512+ shared RAM, bank*128+offset control byte
    function automatic int key_of(input logic [6:0] a);
        int b;
        int x;
        if (a == 7'h00) begin
            b = int'(m_ptr[7]);
            x = int'(m_ptr[6:0]);
            if (x == 0) return -1;
        end else begin
            b = int'(m_stat[5]);
            x = int'(a);
        end
        if (x > 'h4F) return -1;
        if (x == 3) return 1000;
        if (x == 4) return 1001;
        if (x >= 12) return 512 + x;
        return b * 128 + x;
    endfunction

    function automatic logic [7:0] model_read(input logic [6:0] a);
        int k;
        k = key_of(a);
        if (k < 0) return 8'h00;
        if (k == 1000) return m_stat;
        if (k == 1001) return m_ptr;
        return m_mem[k];
    endfunction

    function automatic string auto_tag(input logic [6:0] a);
        if (a > 7'h4F) return "R5";
        if (a == 7'h00) begin
            if (m_ptr[6:0] == 7'h00) return "R7";
            if (m_ptr[6:0] > 7'h4F) return "R9";
            return "R6";
        end
        if (a == 7'h03 || a == 7'h04) return "R4";
        if (a >= 7'h0C) return "R3";
        return "R2";
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [6:0] a, input logic we, input logic [6:0] wa,
                        input logic [7:0] wd, input string tag = "");
        int k;
        @(negedge clk);
        rd_addr = a;
        wr_en   = we;
        wr_addr = wa;
        wr_data = wd;
        #1;
        check((tag == "") ? auto_tag(a) : tag, rd_data, model_read(a));
        check("R4", status_o, m_stat);
        check("R4", ptr_o, m_ptr);
        @(posedge clk);
        if (we) begin
            k = key_of(wa);
            if (k == 1000) m_stat = wd;
            else if (k == 1001) m_ptr = wd;
            else if (k >= 0) m_mem[k] = wd;
        end
    endtask

    task automatic rd(input logic [6:0] a, input string tag = "");
        step(a, 1'b0, 7'h00, 8'h00, tag);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        step(7'h04, 1'b1, a, d);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_stat = 8'h00;
        m_ptr  = 8'h00;
        for (int i = 0; i < 1024; i++) m_mem[i] = 8'h00;
        rst_n = 1'b0; rd_addr = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values in both banks
        for (int a = 0; a < 128; a++) rd(7'(a), "R1");
        wr(7'h03, 8'h20);
        for (int a = 0; a < 128; a++) rd(7'(a), "R1");
        wr(7'h03, 8'h00);

        // R2: control bytes differ per bank
        wr(7'h05, 8'hA5);
        wr(7'h0B, 8'h11);
        wr(7'h03, 8'h20);
        rd(7'h05, "R2");
        wr(7'h05, 8'h5A);
        rd(7'h05, "R2");
        rd(7'h0B, "R2");
        wr(7'h03, 8'h00);
        rd(7'h05, "R2");

        // R3: shared RAM
        wr(7'h20, 8'h33);
        wr(7'h03, 8'h20);
        rd(7'h20, "R3");
        wr(7'h4F, 8'h77);
        wr(7'h0C, 8'h0C);
        wr(7'h03, 8'h00);
        rd(7'h4F, "R3");
        rd(7'h0C, "R3");

        // R4: status and pointer in bank 1
        wr(7'h03, 8'h21);
        rd(7'h03, "R4");
        wr(7'h04, 8'h9E);
        rd(7'h04, "R4");

        // R5: unimplemented
        wr(7'h50, 8'hFF);
        wr(7'h7F, 8'hFF);
        rd(7'h50, "R5");
        rd(7'h7F, "R5");
        rd(7'h4F, "R5");

        // R6: indirection by pointer bank
        wr(7'h04, 8'h20);
        rd(7'h00, "R6");
        wr(7'h03, 8'h80);
        wr(7'h04, 8'h85);
        rd(7'h00, "R6");
        wr(7'h04, 8'h05);
        rd(7'h00, "R6");
        wr(7'h04, 8'h86);
        step(7'h00, 1'b1, 7'h00, 8'h3C, "R6");
        rd(7'h00, "R6");
        rd(7'h06, "R6");
        wr(7'h03, 8'h20);
        rd(7'h06, "R6");
        wr(7'h04, 8'h03);
        rd(7'h00, "R6");

        // R7: self reference reads zero
        wr(7'h04, 8'h00);
        rd(7'h00, "R7");
        wr(7'h04, 8'h80);
        rd(7'h00, "R7");

        // R8: self reference write dropped
        step(7'h00, 1'b1, 7'h00, 8'hEE, "R8");
        rd(7'h04, "R8");
        rd(7'h03, "R8");
        rd(7'h00, "R8");

        // R9: indirect beyond 0x4F
        wr(7'h04, 8'h60);
        rd(7'h00, "R9");
        step(7'h00, 1'b1, 7'h00, 8'hDD, "R9");
        rd(7'h00, "R9");

        // R10: same-cycle read returns old value
        wr(7'h03, 8'h00);
        step(7'h30, 1'b1, 7'h30, 8'h99, "R10");
        rd(7'h30, "R10");
        step(7'h05, 1'b1, 7'h03, 8'h20, "R10");
        rd(7'h05, "R10");

        // mixed traffic
        for (int n = 0; n < 3000; n++) begin
            logic [6:0] ra;
            logic [6:0] wa;
            logic [7:0] wd;
            logic       we;
            ra = 7'($urandom_range(0, 127));
            if ($urandom_range(0, 3) == 0) ra = 7'($urandom_range(0, 12));
            wa = 7'($urandom_range(0, 127));
            if ($urandom_range(0, 2) == 0) wa = 7'($urandom_range(0, 12));
            wd = 8'($urandom);
            we = ($urandom_range(0, 1) == 1);
            step(ra, we, wa, wd);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule